// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block decides how long a CPU bus cycle is stretched. At the first clock of each bus cycle the sequencer presents a start strobe with the cycle kind (memory, I/O, acknowledge of interrupt line 0, or acknowledge of any other interrupt source), the address, the opcode-fetch flag M1, and two hints for on-chip peripherals. The block picks a wait count from that context and from two 2-bit programmable fields. It then raises `wait_o` for exactly that many clocks and pulses `cyc_done` once the cycle may finish.

An external hold input keeps the cycle in wait after the programmed count has run out. The two fields sit in one configuration byte that is written through a small address-decoded port. Reset loads both fields with their largest value. The count is captured when the cycle starts, so rewriting the fields in the middle of a cycle only affects later cycles.

Cycle kinds are encoded on `cyc_kind` as 00 memory, 01 I/O, 10 line-0 acknowledge, 11 other acknowledge. In the configuration byte, bits [1:0] hold the memory field and bits [3:2] hold the I/O field.

Top module: `busw_wait_gen`

## Requirements
- R1: After reset both fields are 11. A memory cycle then gets 3 waits and an I/O cycle to an address above 0x003F gets 4 waits.
- R2: A memory cycle (`cyc_kind`=00) gets 0, 1, 2 or 3 waits for memory field values 00, 01, 10 and 11.
- R3: An I/O cycle (`cyc_kind`=01) to an address above 0x003F gets 1, 2, 3 or 4 waits for I/O field values 00, 01, 10 and 11.
- R4: A line-0 acknowledge (`cyc_kind`=10) with `cyc_m1`=0 gets 2, 4, 5 or 6 waits for I/O field values 00, 01, 10 and 11.
- R5: An other-source acknowledge (`cyc_kind`=11) with `cyc_m1`=0 always gets 2 waits, whatever the fields hold.
- R6: An acknowledge cycle of either kind with `cyc_m1`=1 uses the memory table of R2.
- R7: An I/O cycle to an address from 0x0000 to 0x003F with `sync_sel`=0 gets 0 waits, whatever the I/O field holds.
- R8: An I/O cycle to an address from 0x0000 to 0x003F with `sync_sel`=1 gets `sync_waits` waits, limited to at most 4.
- R9: While `ext_wait` is high during an active cycle, `wait_o` stays high and `cyc_done` stays low, even after the programmed count has run out.
- R10: A write with `cfg_wr`=1 and `cfg_addr` equal to the configuration address (default 0x1A) loads the fields on the next edge. A write during a cycle does not change that cycle's count. A write to any other address changes nothing.
- R11: After a start is accepted while idle, `wait_o` is high for exactly N consecutive clocks and `cyc_done` is then high for one clock. A start while busy is ignored, and `wait_o` and `cyc_done` are low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write address |
| cfg_data | input | 8 | Configuration write data; [1:0] memory field, [3:2] I/O field |
| cyc_start | input | 1 | First clock of a bus cycle |
| cyc_kind | input | 2 | Cycle kind: 00 memory, 01 I/O, 10 line-0 ack, 11 other ack |
| cyc_addr | input | 16 | Cycle address |
| cyc_m1 | input | 1 | Opcode-fetch flag of the cycle |
| sync_sel | input | 1 | On-chip I/O access targets a synchronised data register |
| sync_waits | input | 3 | Wait count requested by peripheral synchronisation |
| ext_wait | input | 1 | External request to hold the cycle |
| wait_o | output | 1 | Wait clock being inserted |
| cyc_done | output | 1 | Cycle may complete this clock |
| cyc_busy | output | 1 | A cycle is in progress |

## Verification
The assertions check the handshake shape on every cycle. They confirm that `wait_o` and `cyc_done` never overlap, that both are silent while idle, and that a held `ext_wait` blocks completion. They also check, each time such a cycle starts, the fixed two waits of other-source acknowledges and the zero-wait entry into the on-chip I/O range. The full count tables, the reset defaults, the clamp on synchronised counts, the timing of a mid-cycle field write and the rejection of writes to other addresses depend on values chosen over several cycles. Only the bench's scenarios, which compare each measured wait run with a queued expectation, show those.

// File: rtl/busw_wait_gen.sv
module busw_wait_gen #(
  parameter int ADDR_W = 16,
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] CFG_ADDR = 8'h1A,
  parameter logic [ADDR_W-1:0] INT_IO_TOP = 16'h003F,
  parameter int SYNC_W = 3,
  parameter int SYNC_MAX = 4,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_data,
  input  logic              cyc_start,
  input  logic [1:0]        cyc_kind,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_m1,
  input  logic              sync_sel,
  input  logic [SYNC_W-1:0] sync_waits,
  input  logic              ext_wait,
  output logic              wait_o,
  output logic              cyc_done,
  output logic              cyc_busy
);
  localparam logic [1:0] K_MEM = 2'b00, K_IO = 2'b01, K_ACK0 = 2'b10, K_ACKX = 2'b11;
  localparam logic [CNT_W-1:0] SYNC_CAP = CNT_W'(SYNC_MAX);

  logic [1:0] mem_fld, io_fld;
  logic [CNT_W-1:0] cnt, need, mem_n, io_n, ack0_n, sync_n;
  logic active, on_chip;

  assign mem_n   = CNT_W'(mem_fld);
  assign io_n    = CNT_W'(io_fld) + CNT_W'(1);
  assign ack0_n  = (io_fld == 2'b00) ? CNT_W'(2) : CNT_W'(io_fld) + CNT_W'(3);
  assign sync_n  = (CNT_W'(sync_waits) > SYNC_CAP) ? SYNC_CAP : CNT_W'(sync_waits);
  assign on_chip = (cyc_addr <= INT_IO_TOP);

  always_comb begin
    need = mem_n;
    case (cyc_kind)
      K_MEM:  need = mem_n;
      K_IO:   need = on_chip ? (sync_sel ? sync_n : '0) : io_n;
      K_ACK0: need = cyc_m1 ? mem_n : ack0_n;
      K_ACKX: need = cyc_m1 ? mem_n : CNT_W'(2);
      default: need = mem_n;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_fld <= 2'b11;
      io_fld  <= 2'b11;
    end else if (cfg_wr && cfg_addr == CFG_ADDR) begin
      mem_fld <= cfg_data[1:0];
      io_fld  <= cfg_data[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (cyc_start) begin
        active <= 1'b1;
        cnt    <= need;
      end
    end else begin
      if (cnt != '0) cnt <= cnt - CNT_W'(1);
      if (cyc_done) active <= 1'b0;
    end
  end

  assign cyc_done = active && (cnt == '0) && !ext_wait;
  assign wait_o   = active && !cyc_done;
  assign cyc_busy = active;
endmodule

module busw_wait_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INT_IO_TOP = 16'h003F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_start,
  input logic [1:0]        cyc_kind,
  input logic [ADDR_W-1:0] cyc_addr,
  input logic              cyc_m1,
  input logic              sync_sel,
  input logic              ext_wait,
  input logic              wait_o,
  input logic              cyc_done,
  input logic              cyc_busy
);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) !(wait_o && cyc_done));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_busy |-> (!wait_o && !cyc_done));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_busy && ext_wait) |-> (wait_o && !cyc_done));
  p_ackx_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_busy && cyc_kind == 2'b11 && !cyc_m1) |=> wait_o ##1 wait_o);
  p_onchip_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_busy && cyc_kind == 2'b01 && cyc_addr <= INT_IO_TOP && !sync_sel)
      |=> (cyc_done || ext_wait));
endmodule

bind busw_wait_gen busw_wait_chk #(.ADDR_W(ADDR_W), .INT_IO_TOP(INT_IO_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
  .cyc_addr(cyc_addr), .cyc_m1(cyc_m1), .sync_sel(sync_sel), .ext_wait(ext_wait),
  .wait_o(wait_o), .cyc_done(cyc_done), .cyc_busy(cyc_busy)
);

// File: tb/tb_busw_wait_gen.sv
module tb_busw_wait_gen;
  localparam time HALF = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_data = '0;
  logic cyc_start = 1'b0, cyc_m1 = 1'b0, sync_sel = 1'b0, ext_wait = 1'b0;
  logic [1:0] cyc_kind = '0;
  logic [15:0] cyc_addr = '0;
  logic [2:0] sync_waits = '0;
  logic wait_o, cyc_done, cyc_busy;

  int vectors = 0, errors = 0, wcnt = 0;
  int exp_q[$];
  string tag_q[$];
  bit live = 1'b0;

  always #HALF clk = ~clk;

  busw_wait_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cyc_start(cyc_start), .cyc_kind(cyc_kind), .cyc_addr(cyc_addr), .cyc_m1(cyc_m1),
    .sync_sel(sync_sel), .sync_waits(sync_waits), .ext_wait(ext_wait),
    .wait_o(wait_o), .cyc_done(cyc_done), .cyc_busy(cyc_busy)
  );

  always @(negedge clk) begin
    #5;
    if (live) begin
      if (wait_o) wcnt++;
      if (cyc_done) begin
        vectors++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R11: unexpected completion, actual done=1 expected done=0");
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (wcnt != e) begin
            errors++;
            $display("FAIL %s: waits actual=%0d expected=%0d", t, wcnt, e);
          end
        end
        wcnt = 0;
      end
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run(input logic [1:0] k, input logic [15:0] a, input logic m1,
                     input logic sel, input logic [2:0] sw, input int exp,
                     input string tag, input int ext_k = 0, input bit restart = 0,
                     input bit mid_wr = 0, input logic [7:0] mid_a = 8'h1A,
                     input logic [7:0] mid_d = 8'h00);
    @(negedge clk);
    cyc_kind = k; cyc_addr = a; cyc_m1 = m1; sync_sel = sel; sync_waits = sw;
    cyc_start = 1'b1; ext_wait = (ext_k > 0);
    exp_q.push_back(exp); tag_q.push_back(tag);
    for (int j = 1; j < 200; j++) begin
      @(negedge clk);
      cyc_start = (restart && j == 2);
      cfg_wr = (mid_wr && j == 2);
      cfg_addr = mid_a; cfg_data = mid_d;
      if (j > ext_k) ext_wait = 1'b0;
      #6;
      if (exp_q.size() == 0) break;
    end
    cyc_start = 1'b0; cfg_wr = 1'b0;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: no completion, actual=pending expected=done", tag);
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    vectors++;
    if (wait_o || cyc_done || cyc_busy) begin
      errors++;
      $display("FAIL R11: reset outputs actual=%b%b%b expected=000", wait_o, cyc_done, cyc_busy);
    end
    rst_n = 1'b1;
    live = 1'b1;

    run(2'b00, 16'h1234, 1'b0, 1'b0, 3'd0, 3, "R1 mem default");
    run(2'b01, 16'h0080, 1'b0, 1'b0, 3'd0, 4, "R1 io default");

    for (int f = 0; f < 4; f++) begin
      cfg_write(8'h1A, 8'(f));
      run(2'b00, 16'h8000, 1'b0, 1'b0, 3'd0, f, "R2 mem table");
      run(2'b11, 16'h0000, 1'b1, 1'b0, 3'd0, f, "R6 ack m1 high mem timing");
    end
    for (int f = 0; f < 4; f++) begin
      cfg_write(8'h1A, 8'(f << 2) | 8'h1);
      run(2'b01, 16'h0040, 1'b0, 1'b0, 3'd0, f + 1, "R3 io table");
      run(2'b10, 16'h0000, 1'b0, 1'b0, 3'd0, (f == 0) ? 2 : f + 3, "R4 int0 ack");
      run(2'b11, 16'h0000, 1'b0, 1'b0, 3'd0, 2, "R5 other ack");
      run(2'b10, 16'h0000, 1'b1, 1'b0, 3'd0, 1, "R6 int0 ack m1 high");
      run(2'b01, 16'h003F, 1'b0, 1'b0, 3'd0, 0, "R7 on-chip io");
      run(2'b01, 16'h0000, 1'b0, 1'b0, 3'd5, 0, "R7 on-chip io sync ignored");
    end

    run(2'b01, 16'h0010, 1'b0, 1'b1, 3'd3, 3, "R8 sync waits");
    run(2'b01, 16'h0010, 1'b0, 1'b1, 3'd7, 4, "R8 sync clamp");
    run(2'b01, 16'h003F, 1'b0, 1'b1, 3'd0, 0, "R8 sync zero");

    cfg_write(8'h1A, 8'h01);
    run(2'b00, 16'h0100, 1'b0, 1'b0, 3'd0, 4, "R9 hold beyond count", 4);
    cfg_write(8'h1A, 8'h03);
    run(2'b00, 16'h0100, 1'b0, 1'b0, 3'd0, 3, "R9 short hold", 1);
    cfg_write(8'h1A, 8'h00);
    run(2'b00, 16'h0100, 1'b0, 1'b0, 3'd0, 2, "R9 hold on zero count", 2);

    cfg_write(8'h1A, 8'h0F);
    run(2'b01, 16'h0200, 1'b0, 1'b0, 3'd0, 4, "R10 mid-cycle write", 0, 0, 1, 8'h1A, 8'h00);
    run(2'b01, 16'h0200, 1'b0, 1'b0, 3'd0, 1, "R10 write applies next cycle");
    cfg_write(8'h1B, 8'h0F);
    run(2'b01, 16'h0200, 1'b0, 1'b0, 3'd0, 1, "R10 other address ignored");
    run(2'b00, 16'h0200, 1'b0, 1'b0, 3'd0, 0, "R10 other address ignored mem");

    cfg_write(8'h1A, 8'h03);
    run(2'b00, 16'h0300, 1'b0, 1'b0, 3'd0, 3, "R11 restart while busy", 0, 1);
    repeat (6) @(negedge clk);

    #7;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule